// File: doc/BRIEF.md
# TLB Range Invalidation Controller

This block owns the tag and valid state of two small translation lookaside buffers and lets software drop stale entries after it edits the page tables. Software first chooses which of the two buffers a command should reach, then issues either a full flush or a flush of an inclusive address window. A full flush empties every selected buffer in one clock. A window flush starts a sequencer that visits one entry per clock in both buffers at once. It invalidates each valid entry whose page number lies between the window's first and last page.

Completion is reported through a sticky flag that software polls and then clears by writing zero to it. While a window flush is running, a busy bit can be read and further commands are dropped. Entries are loaded through a refill port, which stands in for the translation unit's miss path. The live valid vectors of both buffers are driven out to the lookup logic, which sits outside this block.

Top module: `tlb_range_inval`

## Requirements
- R1: After reset, every valid bit of both buffers is 0, and the busy bit, done flag, select register and both window registers all read 0.
- R2: A refill cycle (`fill_en` high) writes `fill_tag` into entry `fill_idx` of the buffer named by `fill_tlb` (0 or 1) and sets that entry valid at the next clock edge.
- R3: The select register at offset 0x038 holds the targets in bit 0 (buffer 0) and bit 1 (buffer 1). A flush never changes any entry of a buffer whose select bit is 0.
- R4: A write to the command register at offset 0x020 with bit 1 set clears every valid bit of each selected buffer at that clock edge and sets the done flag. Bit 1 wins over bit 0 when both are set, and no walk starts.
- R5: A write to offset 0x020 with bit 0 set and bit 1 clear starts a window flush. It clears each valid entry of a selected buffer whose tag satisfies start[31:12] <= tag <= end[31:12], where start is at offset 0x024 and end at offset 0x028. Bits 11:0 of both addresses are ignored. Entries outside the window keep their state.
- R6: A window flush visits one entry per clock in both buffers in parallel. Bit 0 of a read of offset 0x020 (busy) reads 1 for exactly ENTRIES cycles after the command edge. The done flag rises on the edge where busy falls and reads 0 before then.
- R7: Bit 0 of offset 0x12C reads 1 once the done flag is set and stays 1 until software writes the value 0 there. Writing a nonzero value leaves it set.
- R8: A command written while busy is 1 is ignored: the running walk continues unchanged and no flush of either kind starts.
- R9: If the end page is below the start page, the window flush clears nothing, but it still runs its full walk and sets the done flag.
- R10: The window bounds and the select bits are captured when a window flush starts. Writes to offsets 0x024, 0x028 or 0x038 during the walk do not affect it, but those registers still take the new values.
- R11: Offsets 0x024, 0x028 and 0x038 read back the last written value (the select register holds 2 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| fill_en | input | 1 | Refill strobe |
| fill_tlb | input | 1 | Buffer receiving the refill |
| fill_idx | input | log2(ENTRIES) | Entry index of the refill |
| fill_tag | input | ADDR_W-PAGE_SHIFT | Page number stored by the refill |
| tlb0_valid | output | ENTRIES | Valid bits of buffer 0 |
| tlb1_valid | output | ENTRIES | Valid bits of buffer 1 |

## Verification
The hardest state to reach is a command that lands while the walk is still running, because the window is only ENTRIES cycles wide. The stimulus starts a window flush and then, on the very next clocks, issues a full-flush command and rewrites the end address and the select register. Only entries inside the originally captured window may be gone afterwards. The window uses tags that sit exactly on the first and last page, plus their outer neighbours, and one buffer is filled in descending page order so that the parallel walk meets matches at different indices in the two buffers.

// File: rtl/tlbinv_pkg.sv
// Package: shared register offsets and command bit positions of the
// TLB range invalidation controller. Assumes a byte-addressed bus.
package tlbinv_pkg;
    localparam int NUM_TLB = 2;

    localparam logic [11:0] OFS_CMD  = 12'h020;
    localparam logic [11:0] OFS_LO   = 12'h024;
    localparam logic [11:0] OFS_HI   = 12'h028;
    localparam logic [11:0] OFS_SEL  = 12'h038;
    localparam logic [11:0] OFS_DONE = 12'h12C;

    localparam int CMD_RANGE_BIT = 0;
    localparam int CMD_ALL_BIT   = 1;
endpackage

// File: rtl/tlbinv_tag_array.sv
// Module: tag and valid storage of one TLB. Each entry is a separate
// register with its own update process. A refill has priority over a
// clear of the same entry in the same cycle. Assumes ENTRIES >= 2.
module tlbinv_tag_array #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic              flush,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              rd_valid,
    output logic [ENTRIES-1:0] valid_vec
);
    logic             valid_e [ENTRIES];
    logic [TAG_W-1:0] tag_e   [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        // One entry: refill sets it, flush or walk clear drops it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_e[i] <= 1'b0;
                tag_e[i]   <= '0;
            end else if (fill_en && fill_idx == IDX_W'(i)) begin
                valid_e[i] <= 1'b1;
                tag_e[i]   <= fill_tag;
            end else if (flush || (clr_en && rd_idx == IDX_W'(i))) begin
                valid_e[i] <= 1'b0;
            end
        end
        assign valid_vec[i] = valid_e[i];
    end

    // Read port used by the walker's comparator.
    always_comb begin
        rd_tag   = tag_e[rd_idx];
        rd_valid = valid_e[rd_idx];
    end

    assert_quiet_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_en && !flush && !clr_en) |=> $stable(valid_vec));
    assert_flush_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !fill_en) |=> (valid_vec == '0));
endmodule

// File: rtl/tlbinv_walker.sv
// Module: window flush sequencer. It captures the bounds and the select
// bits on start, then steps one index per clock over both buffers and
// asks each selected buffer to drop the current entry when its tag is
// inside the window. A start request while busy is ignored.
module tlbinv_walker
    import tlbinv_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            range_go,
    input  logic [NUM_TLB-1:0]              sel_in,
    input  logic [TAG_W-1:0]                lo_in,
    input  logic [TAG_W-1:0]                hi_in,
    input  logic [NUM_TLB-1:0][TAG_W-1:0]   rd_tag,
    input  logic [NUM_TLB-1:0]              rd_valid,
    output logic [IDX_W-1:0]                walk_idx,
    output logic [NUM_TLB-1:0]              clr,
    output logic                            busy,
    output logic                            walk_done
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [NUM_TLB-1:0] sel_q;
    logic [TAG_W-1:0]   lo_q;
    logic [TAG_W-1:0]   hi_q;

    // Launch, step and finish of the walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            walk_idx <= '0;
            sel_q    <= '0;
            lo_q     <= '0;
            hi_q     <= '0;
        end else if (!busy) begin
            if (range_go) begin
                busy     <= 1'b1;
                walk_idx <= '0;
                sel_q    <= sel_in;
                lo_q     <= lo_in;
                hi_q     <= hi_in;
            end
        end else if (walk_idx == LAST) begin
            busy     <= 1'b0;
            walk_idx <= '0;
        end else begin
            walk_idx <= walk_idx + 1'b1;
        end
    end

    // Per-buffer window comparator.
    for (genvar t = 0; t < NUM_TLB; t++) begin : g_cmp
        assign clr[t] = busy && sel_q[t] && rd_valid[t] &&
                        (rd_tag[t] >= lo_q) && (rd_tag[t] <= hi_q);
    end

    assign walk_done = busy && (walk_idx == LAST);

    assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && walk_idx != LAST) |=> (busy && walk_idx == $past(walk_idx) + 1'b1));
    assert_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |=> !busy);
    assert_ignore_go_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && walk_idx != LAST) |=> ($stable(lo_q) && $stable(hi_q) && $stable(sel_q)));
    assert_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (walk_idx <= LAST));
endmodule

// File: rtl/tlbinv_regs.sv
// Module: register file and command decode. Holds the window addresses,
// the select bits and the sticky done flag, and turns command writes
// into one-cycle start pulses while the walker is idle.
module tlbinv_regs
    import tlbinv_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int BUS_AW     = 12,
    localparam int TAG_W     = ADDR_W - PAGE_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               busy,
    input  logic               walk_done,
    output logic [NUM_TLB-1:0] sel_o,
    output logic [TAG_W-1:0]   lo_page,
    output logic [TAG_W-1:0]   hi_page,
    output logic               range_go,
    output logic               full_go
);
    logic [ADDR_W-1:0] lo_q;
    logic [ADDR_W-1:0] hi_q;
    logic              done_q;
    logic              wr;
    logic              cmd_wr;
    logic              done_clr;

    // Write and command decode.
    always_comb begin
        wr       = bus_en && bus_we;
        cmd_wr   = wr && (bus_addr == BUS_AW'(OFS_CMD)) && !busy;
        full_go  = cmd_wr && bus_wdata[CMD_ALL_BIT];
        range_go = cmd_wr && bus_wdata[CMD_RANGE_BIT] && !bus_wdata[CMD_ALL_BIT];
        done_clr = wr && (bus_addr == BUS_AW'(OFS_DONE)) && (bus_wdata == 32'd0);
    end

    // Software-visible registers; a set of done wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= '0;
            hi_q   <= '0;
            sel_o  <= '0;
            done_q <= 1'b0;
        end else begin
            if (wr && bus_addr == BUS_AW'(OFS_LO))  lo_q  <= bus_wdata[ADDR_W-1:0];
            if (wr && bus_addr == BUS_AW'(OFS_HI))  hi_q  <= bus_wdata[ADDR_W-1:0];
            if (wr && bus_addr == BUS_AW'(OFS_SEL)) sel_o <= bus_wdata[NUM_TLB-1:0];
            if (full_go || walk_done)               done_q <= 1'b1;
            else if (done_clr)                      done_q <= 1'b0;
        end
    end

    assign lo_page = lo_q[ADDR_W-1:PAGE_SHIFT];
    assign hi_page = hi_q[ADDR_W-1:PAGE_SHIFT];

    // Read mux.
    always_comb begin
        case (bus_addr)
            BUS_AW'(OFS_CMD):  bus_rdata = {31'd0, busy};
            BUS_AW'(OFS_LO):   bus_rdata = 32'(lo_q);
            BUS_AW'(OFS_HI):   bus_rdata = 32'(hi_q);
            BUS_AW'(OFS_SEL):  bus_rdata = 32'(sel_o);
            BUS_AW'(OFS_DONE): bus_rdata = {31'd0, done_q};
            default:           bus_rdata = 32'd0;
        endcase
    end

    assert_done_on_walk_R6: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |=> done_q);
    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !done_clr) |=> done_q);
    assert_done_on_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        full_go |=> done_q);
    assert_go_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_go && range_go));
endmodule

// File: rtl/tlb_range_inval.sv
// Module: top of the TLB range invalidation controller. Connects the
// register file, the window walker and one tag array per TLB. The
// refill port and the valid outputs face the translation logic.
module tlb_range_inval
    import tlbinv_pkg::*;
#(
    parameter int ENTRIES    = 8,
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int BUS_AW     = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_en,
    input  logic                         bus_we,
    input  logic [BUS_AW-1:0]            bus_addr,
    input  logic [31:0]                  bus_wdata,
    output logic [31:0]                  bus_rdata,
    input  logic                         fill_en,
    input  logic                         fill_tlb,
    input  logic [$clog2(ENTRIES)-1:0]   fill_idx,
    input  logic [ADDR_W-PAGE_SHIFT-1:0] fill_tag,
    output logic [ENTRIES-1:0]           tlb0_valid,
    output logic [ENTRIES-1:0]           tlb1_valid
);
    localparam int TAG_W = ADDR_W - PAGE_SHIFT;
    localparam int IDX_W = $clog2(ENTRIES);

    logic [NUM_TLB-1:0]            sel;
    logic [TAG_W-1:0]              lo_page;
    logic [TAG_W-1:0]              hi_page;
    logic                          range_go;
    logic                          full_go;
    logic                          busy;
    logic                          walk_done;
    logic [IDX_W-1:0]              walk_idx;
    logic [NUM_TLB-1:0]            clr;
    logic [NUM_TLB-1:0][TAG_W-1:0] rd_tag;
    logic [NUM_TLB-1:0]            rd_valid;
    logic [NUM_TLB-1:0][ENTRIES-1:0] valid_all;

    tlbinv_regs #(
        .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .BUS_AW(BUS_AW)
    ) i_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .walk_done(walk_done),
        .sel_o(sel), .lo_page(lo_page), .hi_page(hi_page),
        .range_go(range_go), .full_go(full_go)
    );

    tlbinv_walker #(
        .ENTRIES(ENTRIES), .TAG_W(TAG_W)
    ) i_walker (
        .clk(clk), .rst_n(rst_n),
        .range_go(range_go), .sel_in(sel), .lo_in(lo_page), .hi_in(hi_page),
        .rd_tag(rd_tag), .rd_valid(rd_valid),
        .walk_idx(walk_idx), .clr(clr), .busy(busy), .walk_done(walk_done)
    );

    for (genvar t = 0; t < NUM_TLB; t++) begin : g_tlb
        logic [TAG_W-1:0] tag_t;
        logic             vld_t;
        tlbinv_tag_array #(
            .ENTRIES(ENTRIES), .TAG_W(TAG_W)
        ) i_array (
            .clk(clk), .rst_n(rst_n),
            .fill_en(fill_en && (fill_tlb == 1'(t))),
            .fill_idx(fill_idx), .fill_tag(fill_tag),
            .flush(full_go && sel[t]),
            .clr_en(clr[t]), .rd_idx(walk_idx),
            .rd_tag(tag_t), .rd_valid(vld_t),
            .valid_vec(valid_all[t])
        );
        assign rd_tag[t]   = tag_t;
        assign rd_valid[t] = vld_t;
    end

    assign tlb0_valid = valid_all[0];
    assign tlb1_valid = valid_all[1];
endmodule

// File: tb/test_tlb_range_inval.sv
// Directed bench: one task per scenario, each checking its own results
// against a bench-side model of both buffers.
module test_tlb_range_inval;
    localparam int N  = 8;
    localparam int TW = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fill_en = 1'b0, fill_tlb = 1'b0;
    logic [2:0]  fill_idx = '0;
    logic [TW-1:0] fill_tag = '0;
    logic [N-1:0] tlb0_valid, tlb1_valid;

    int checks = 0;
    int fails  = 0;

    logic [TW-1:0] m_tag [2][N];
    bit            m_v   [2][N];

    always #2 clk = ~clk;

    tlb_range_inval i_tlb_range_inval (
        .clk(clk), .rst_n(rst_n),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fill_en(fill_en), .fill_tlb(fill_tlb), .fill_idx(fill_idx),
        .fill_tag(fill_tag),
        .tlb0_valid(tlb0_valid), .tlb1_valid(tlb1_valid)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #0.5;
        d = bus_rdata;
        bus_en = 1'b0;
    endtask

    function automatic logic [N-1:0] expv(input int t);
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = m_v[t][i];
        return v;
    endfunction

    task automatic model_range(input logic [1:0] sel, input logic [31:0] lo, input logic [31:0] hi);
        for (int t = 0; t < 2; t++)
            for (int i = 0; i < N; i++)
                if (sel[t] && m_tag[t][i] >= lo[31:12] && m_tag[t][i] <= hi[31:12])
                    m_v[t][i] = 1'b0;
    endtask

    // Buffer 0 ascending pages 0x100.., buffer 1 descending from 0x104.
    task automatic refill_all();
        for (int t = 0; t < 2; t++)
            for (int i = 0; i < N; i++) begin
                @(negedge clk);
                fill_en = 1'b1; fill_tlb = 1'(t); fill_idx = 3'(i);
                fill_tag = (t == 0) ? TW'(20'h00100 + i) : TW'(20'h00104 - i);
                m_tag[t][i] = fill_tag;
                m_v[t][i] = 1'b1;
                @(posedge clk);
                #1;
                fill_en = 1'b0;
            end
    endtask

    task automatic wait_walk(input string req, output int cycles);
        logic [31:0] d;
        cycles = 0;
        bus_read(12'h020, d);
        while (d[0]) begin
            cycles++;
            @(posedge clk);
            #1;
            bus_read(12'h020, d);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 tlb0 valid", 32'(tlb0_valid), 32'd0);
        check("R1 tlb1 valid", 32'(tlb1_valid), 32'd0);
        bus_read(12'h020, d); check("R1 busy", d, 32'd0);
        bus_read(12'h12C, d); check("R1 done", d, 32'd0);
        bus_read(12'h038, d); check("R1 select", d, 32'd0);
        bus_read(12'h024, d); check("R1 start", d, 32'd0);
    endtask

    task automatic t_fill();
        refill_all();
        check("R2 tlb0 filled", 32'(tlb0_valid), 32'(expv(0)));
        check("R2 tlb1 filled", 32'(tlb1_valid), 32'(expv(1)));
    endtask

    task automatic t_full_both();
        logic [31:0] d;
        bus_write(12'h038, 32'd3);
        bus_write(12'h020, 32'd2);
        check("R4 full flush tlb0", 32'(tlb0_valid), 32'd0);
        check("R4 full flush tlb1", 32'(tlb1_valid), 32'd0);
        bus_read(12'h12C, d); check("R4 done after full flush", d, 32'd1);
        bus_write(12'h12C, 32'd5);
        bus_read(12'h12C, d); check("R7 nonzero write keeps done", d, 32'd1);
        bus_write(12'h12C, 32'd0);
        bus_read(12'h12C, d); check("R7 zero write clears done", d, 32'd0);
    endtask

    task automatic t_full_one();
        logic [31:0] d;
        refill_all();
        bus_write(12'h038, 32'd2);
        bus_read(12'h038, d); check("R11 select readback", d, 32'd2);
        bus_write(12'h020, 32'd3);
        bus_read(12'h020, d); check("R4 both bits: no walk", d, 32'd0);
        for (int i = 0; i < N; i++) m_v[1][i] = 1'b0;
        check("R3 unselected tlb0 kept", 32'(tlb0_valid), 32'(expv(0)));
        check("R4 selected tlb1 flushed", 32'(tlb1_valid), 32'(expv(1)));
        bus_read(12'h12C, d); check("R4 done set", d, 32'd1);
        bus_write(12'h12C, 32'd0);
    endtask

    task automatic t_range(input logic [1:0] sel, input string req);
        logic [31:0] d;
        int cyc;
        refill_all();
        bus_write(12'h038, 32'(sel));
        bus_write(12'h024, 32'h0010_2345);
        bus_write(12'h028, 32'h0010_5FFF);
        bus_read(12'h028, d); check("R11 end readback", d, 32'h0010_5FFF);
        bus_write(12'h020, 32'd1);
        bus_read(12'h12C, d); check({req, " R6 done low while busy"}, d, 32'd0);
        wait_walk(req, cyc);
        check({req, " R6 busy cycles"}, 32'(cyc), 32'(N));
        bus_read(12'h12C, d); check({req, " R6 done at end"}, d, 32'd1);
        model_range(sel, 32'h0010_2345, 32'h0010_5FFF);
        check({req, " R5 tlb0 window"}, 32'(tlb0_valid), 32'(expv(0)));
        check({req, " R5 tlb1 window"}, 32'(tlb1_valid), 32'(expv(1)));
        bus_write(12'h12C, 32'd0);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] d;
        int cyc;
        refill_all();
        bus_write(12'h038, 32'd3);
        bus_write(12'h024, 32'h0010_3000);
        bus_write(12'h028, 32'h0010_3FFF);
        bus_write(12'h020, 32'd1);
        bus_write(12'h020, 32'd2);
        bus_write(12'h028, 32'hFFFF_FFFF);
        bus_write(12'h038, 32'd0);
        bus_write(12'h020, 32'd1);
        wait_walk("R8", cyc);
        model_range(2'd3, 32'h0010_3000, 32'h0010_3FFF);
        check("R8 tlb0 only captured window", 32'(tlb0_valid), 32'(expv(0)));
        check("R10 tlb1 only captured window", 32'(tlb1_valid), 32'(expv(1)));
        bus_read(12'h028, d); check("R10 end register updated", d, 32'hFFFF_FFFF);
        bus_read(12'h038, d); check("R10 select register updated", d, 32'd0);
        bus_write(12'h12C, 32'd0);
    endtask

    task automatic t_reversed();
        logic [31:0] d;
        int cyc;
        refill_all();
        bus_write(12'h038, 32'd3);
        bus_write(12'h024, 32'h0010_5000);
        bus_write(12'h028, 32'h0010_2000);
        bus_write(12'h020, 32'd1);
        wait_walk("R9", cyc);
        check("R9 walk length", 32'(cyc), 32'(N));
        check("R9 tlb0 untouched", 32'(tlb0_valid), 32'hFF);
        check("R9 tlb1 untouched", 32'(tlb1_valid), 32'hFF);
        bus_read(12'h12C, d); check("R9 done still set", d, 32'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_fill();
        t_full_both();
        t_full_one();
        t_range(2'd1, "tlb0 only");
        t_range(2'd3, "both");
        t_busy_ignore();
        t_reversed();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule